// File: doc/BRIEF.md
# Host Bus Activity Watchdog

This block watches a host that programs a device over a serial register bus and raises a reset request when the host falls silent for too long. The bus decoder delivers a single-cycle strobe for every completed transaction; a free-running one-second tick supplies the time base. The watchdog stays idle after reset and only begins timing once the host has issued its first transaction. From then on, every transaction restarts the count.

A two-bit mode select picks what happens on timeout. It can ask for selected registers to return to their defaults after the long interval, ask for a full hardware reset after the long interval, ask for a hardware reset after the short interval, or switch the watchdog off. The long and short intervals are parameters, 160 and 40 seconds by default. Each request is a single-cycle pulse. After a timeout the watchdog returns to idle until the host speaks again.

Top module: `host_idle_watchdog`

## Requirements
- R1: After reset both request outputs are low and the watchdog is idle; no request is ever raised until a transaction strobe has been seen with the watchdog enabled, however many ticks arrive.
- R2: Every transaction strobe restarts the count from zero, so a timeout is measured from the most recent transaction.
- R3: With mode 2'b00, the register-default request pulses in the cycle after the LONG_SECS-th tick following the last transaction, and the hardware-reset request stays low.
- R4: With mode 2'b01, the hardware-reset request pulses in the cycle after the LONG_SECS-th tick following the last transaction, and the register-default request stays low.
- R5: With mode 2'b10, the hardware-reset request pulses in the cycle after the SHORT_SECS-th tick following the last transaction, and the register-default request stays low.
- R6: With mode 2'b11, the watchdog is off: no request is raised, and transactions in this mode do not arm it; on leaving 2'b11 it stays idle until the next transaction.
- R7: After a timeout the watchdog returns to idle and raises no further request until another transaction arrives.
- R8: A change of the mode select while armed restarts the count, so the new mode's interval runs from the change; a change while idle does not arm the watchdog.
- R9: When a transaction strobe and the tick that would complete the interval arrive in the same cycle, the transaction wins: no request is raised and the count restarts.
- R10: Each request is exactly one cycle wide and the two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_done_i | input | 1 | One-cycle strobe per completed host transaction |
| mode_sel_i | input | 2 | Timeout mode: 00 registers/long, 01 hardware/long, 10 hardware/short, 11 off |
| sec_tick_i | input | 1 | One-cycle pulse each second |
| regs_default_o | output | 1 | One-cycle request to restore selected registers to defaults |
| hw_reset_o | output | 1 | One-cycle request for a full hardware reset |

## Verification
The timeout is exercised in each of the four modes with tick runs that stop one short of the interval and runs that reach it, which separates the long from the short interval and the register request from the hardware request. Transaction strobes mid-count, a strobe landing on the completing tick, and a mode change while armed distinguish a true restart from a count that merely pauses. Long tick runs with no transaction after reset, after a timeout and after leaving the off mode tell an idle watchdog apart from one that re-arms on its own.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        WM_REGS_LONG = 2'b00,
        WM_HW_LONG   = 2'b01,
        WM_HW_SHORT  = 2'b10,
        WM_OFF       = 2'b11
    } wdg_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_REGS = 2'd1,
        ACT_HW   = 2'd2
    } wdg_act_e;

    typedef struct packed {
        logic regs;
        logic hw;
    } wdg_req_t;

    function automatic wdg_act_e action_of(wdg_mode_e m);
        case (m)
            WM_REGS_LONG: return ACT_REGS;
            WM_HW_LONG:   return ACT_HW;
            WM_HW_SHORT:  return ACT_HW;
            default:      return ACT_NONE;
        endcase
    endfunction

    function automatic logic uses_short(wdg_mode_e m);
        return m == WM_HW_SHORT;
    endfunction

endpackage

// File: rtl/wdg_mode_decode.sv
module wdg_mode_decode
    import wdg_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int LONG_SECS  = 160,
    parameter int SHORT_SECS = 40
) (
    input  logic [1:0]       mode_raw,
    output logic [CNT_W-1:0] limit,
    output wdg_act_e         act,
    output logic             off
);
    wdg_mode_e mode;

    always_comb begin
        mode  = wdg_mode_e'(mode_raw);
        limit = uses_short(mode) ? CNT_W'(SHORT_SECS) : CNT_W'(LONG_SECS);
        act   = action_of(mode);
        off   = (mode == WM_OFF);
    end
endmodule

// File: rtl/wdg_idle_counter.sv
module wdg_idle_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             txn,
    input  logic             restart,
    input  logic             off,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             armed,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;
    logic             last_sec;

    always_comb begin
        last_sec = (cnt >= limit - CNT_W'(1));
        expire   = armed && !off && !txn && !restart && tick && last_sec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (off) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (txn) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (restart) begin
            cnt   <= '0;
        end else if (expire) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (armed && tick) begin
            cnt   <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdg_req_gen.sv
module wdg_req_gen
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     expire,
    input  wdg_act_e act,
    output wdg_req_t req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
        end else begin
            req.regs <= expire && (act == ACT_REGS);
            req.hw   <= expire && (act == ACT_HW);
        end
    end
endmodule

// File: rtl/host_idle_watchdog.sv
module host_idle_watchdog
    import wdg_pkg::*;
#(
    parameter int LONG_SECS  = 160,
    parameter int SHORT_SECS = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       txn_done_i,
    input  logic [1:0] mode_sel_i,
    input  logic       sec_tick_i,
    output logic       regs_default_o,
    output logic       hw_reset_o
);
    localparam int RAW_W = $clog2(LONG_SECS + 1);
    localparam int CNT_W = (RAW_W < 1) ? 1 : RAW_W;

    logic [1:0]       mode_q;
    logic             mode_changed;
    logic [CNT_W-1:0] limit;
    wdg_act_e         act;
    logic             off;
    logic             armed;
    logic             expire;
    wdg_req_t         req;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= WM_REGS_LONG;
        else     mode_q <= mode_sel_i;
    end

    always_comb mode_changed = (mode_sel_i != mode_q);

    wdg_mode_decode #(
        .CNT_W(CNT_W), .LONG_SECS(LONG_SECS), .SHORT_SECS(SHORT_SECS)
    ) u_decode (
        .mode_raw(mode_sel_i), .limit(limit), .act(act), .off(off)
    );

    wdg_idle_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .txn(txn_done_i), .restart(mode_changed),
        .off(off), .tick(sec_tick_i), .limit(limit),
        .armed(armed), .expire(expire)
    );

    wdg_req_gen u_req (
        .clk(clk), .rst(rst), .expire(expire), .act(act), .req(req)
    );

    assign regs_default_o = req.regs;
    assign hw_reset_o     = req.hw;
endmodule

// File: rtl/host_idle_watchdog_chk.sv
module host_idle_watchdog_chk (
    input logic       clk,
    input logic       rst,
    input logic       txn_done_i,
    input logic [1:0] mode_sel_i,
    input logic       regs_default_o,
    input logic       hw_reset_o
);
    logic seen_txn;

    always_ff @(posedge clk) begin
        if (rst)                                  seen_txn <= 1'b0;
        else if (txn_done_i && mode_sel_i != 2'b11) seen_txn <= 1'b1;
    end

    assert_quiet_before_txn_R1: assert property (@(posedge clk) disable iff (rst)
        !seen_txn |-> (!regs_default_o && !hw_reset_o));

    assert_txn_blocks_req_R9: assert property (@(posedge clk) disable iff (rst)
        txn_done_i |=> (!regs_default_o && !hw_reset_o));

    assert_regs_mode_R3: assert property (@(posedge clk) disable iff (rst)
        regs_default_o |-> ($past(mode_sel_i) == 2'b00));

    assert_hw_mode_R5: assert property (@(posedge clk) disable iff (rst)
        hw_reset_o |-> ($past(mode_sel_i) == 2'b01 || $past(mode_sel_i) == 2'b10));

    assert_off_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_sel_i == 2'b11) |=> (!regs_default_o && !hw_reset_o));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({regs_default_o, hw_reset_o}));

    assert_regs_single_R7: assert property (@(posedge clk) disable iff (rst)
        regs_default_o |=> !regs_default_o);

    assert_hw_single_R7: assert property (@(posedge clk) disable iff (rst)
        hw_reset_o |=> !hw_reset_o);
endmodule

bind host_idle_watchdog host_idle_watchdog_chk u_chk (
    .clk(clk), .rst(rst), .txn_done_i(txn_done_i), .mode_sel_i(mode_sel_i),
    .regs_default_o(regs_default_o), .hw_reset_o(hw_reset_o)
);

// File: tb/tb_host_idle_watchdog.sv
module tb_host_idle_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int LONG_T  = 8;
    localparam int SHORT_T = 3;

    typedef struct packed {
        logic [1:0] mode;
        logic [4:0] nticks;
        logic       want_regs;
        logic       want_hw;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 5'd8,  1'b1, 1'b0},
        '{2'b00, 5'd7,  1'b0, 1'b0},
        '{2'b01, 5'd8,  1'b0, 1'b1},
        '{2'b01, 5'd7,  1'b0, 1'b0},
        '{2'b10, 5'd3,  1'b0, 1'b1},
        '{2'b10, 5'd2,  1'b0, 1'b0},
        '{2'b11, 5'd12, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       txn = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       tick = 1'b0;
    logic       regs_o;
    logic       hw_o;

    int checks = 0;
    int fails  = 0;

    host_idle_watchdog #(.LONG_SECS(LONG_T), .SHORT_SECS(SHORT_T)) dut (
        .clk(clk), .rst(rst), .txn_done_i(txn), .mode_sel_i(mode),
        .sec_tick_i(tick), .regs_default_o(regs_o), .hw_reset_o(hw_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic er, input logic eh);
        checks++;
        if (regs_o !== er || hw_o !== eh) begin
            fails++;
            $display("FAIL %s: actual regs=%b hw=%b expected regs=%b hw=%b",
                     req, regs_o, hw_o, er, eh);
        end
    endtask

    task automatic send_txn();
        @(negedge clk) txn = 1'b1;
        @(negedge clk) txn = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk) mode = m;
    endtask

    // one tick; outputs sampled one cycle later
    task automatic one_tick(input string req, input logic er, input logic eh);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        check(req, er, eh);
    endtask

    task automatic quiet_ticks(input string req, input int n);
        for (int i = 0; i < n; i++) one_tick(req, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 1'b0, 1'b0);
        // R1: no transaction yet, ticks must not time out
        quiet_ticks("R1 idle before first txn", 20);

        // table walk: R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            int lim;
            set_mode(VECS[v].mode);
            @(negedge clk);
            send_txn();
            lim = (VECS[v].mode == 2'b10) ? SHORT_T : LONG_T;
            for (int i = 1; i <= int'(VECS[v].nticks); i++) begin
                one_tick($sformatf("R3/R4/R5/R6 vec%0d tick%0d", v, i),
                         VECS[v].want_regs && (i == lim),
                         VECS[v].want_hw && (i == lim));
            end
        end

        // R6: leaving off mode does not arm
        set_mode(2'b10);
        quiet_ticks("R6 idle after leaving off", 6);

        // R7 + R10: pulse width and no re-arm after timeout
        send_txn();
        quiet_ticks("R5 short count", 2);
        one_tick("R5 short timeout", 1'b0, 1'b1);
        @(negedge clk);
        check("R10 one-cycle pulse", 1'b0, 1'b0);
        quiet_ticks("R7 idle after timeout", 10);

        // R2: transaction mid-count restarts
        send_txn();
        quiet_ticks("R2 before restart", 2);
        send_txn();
        quiet_ticks("R2 after restart", 2);
        one_tick("R2 timeout from last txn", 1'b0, 1'b1);

        // R9: transaction on the completing tick wins
        send_txn();
        quiet_ticks("R9 count", 2);
        @(negedge clk) begin txn = 1'b1; tick = 1'b1; end
        @(negedge clk) begin txn = 1'b0; tick = 1'b0; end
        check("R9 tie no request", 1'b0, 1'b0);
        quiet_ticks("R9 restarted", 2);
        one_tick("R9 later timeout", 1'b0, 1'b1);

        // R8: mode change while armed restarts with new interval
        set_mode(2'b01);
        @(negedge clk);
        send_txn();
        quiet_ticks("R8 long count", 5);
        set_mode(2'b10);
        quiet_ticks("R8 after change", 2);
        one_tick("R8 new interval timeout", 1'b0, 1'b1);
        // R8: change while idle does not arm
        set_mode(2'b00);
        quiet_ticks("R8 idle change", 10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule